// File: doc/BRIEF.md
# Machine Cycle and Timer Tick Generator

This block is the timing sequencer of an 8051-compatible core whose machine cycle lasts four oscillator clocks, not twelve. It splits the clock into four-clock machine cycles and drives a one-hot phase vector. It also drives an address-latch-enable strobe, which is high for the first half of every machine cycle.

The decoder supplies, per instruction, how many machine cycles the instruction needs (one to five). The sequencer reports which machine cycle of the instruction is running. It raises a final-cycle flag in the last clock of the instruction. On the next edge it captures the length of the following instruction.

The block also feeds up to three counter/timers with increment-enable pulses. Each timer has a rate select bit. With the bit clear, the timer runs at the legacy rate of one pulse per twelve clocks. With the bit set, it runs at the fast rate of one pulse per machine cycle.

Top module: `mcyc_timing_gen`

## Requirements
- R1: `phase_o` is one-hot and steps from bit 0 to bit 3 on successive clocks, then wraps to bit 0. A machine cycle is exactly four clocks, with bit 0 marking its first clock.
- R2: `ale_o` is high while phase bit 0 or bit 1 is set and low during phases 2 and 3, so there is one pulse per machine cycle.
- R3: An instruction of N machine cycles occupies 4*N clocks. `mcyc_idx_o` counts 0..N-1 and advances only on the edge that leaves phase 3. `last_cyc_o` is high only in phase 3 of machine cycle N-1.
- R4: The length of the next instruction is sampled from `cyc_count_i` on the edge that ends an instruction (the edge after `last_cyc_o`), and on every clock edge while reset is held. `mcyc_idx_o` returns to 0 on that edge.
- R5: A count of 2 gives an 8-clock instruction (external-data move). A count of 3 gives a 12-clock instruction (direct-to-direct move).
- R6: A count of 0, 6 or 7 is treated as 1, giving a 4-clock instruction.
- R7: With its select bit 0, a timer's `tmr_tick_o` bit pulses for one clock every 12 clocks. The pulse falls in phase 3 of every third machine cycle, counted from reset; the first pulse is on clock 11 after reset release.
- R8: With its select bit 1, a timer's tick bit pulses in phase 3 of every machine cycle (every 4 clocks).
- R9: `tmr_fast_i` is sampled once per machine cycle, on the edge entering phase 0. A change inside a machine cycle has no effect on that cycle's tick, so no pulse is added or lost.
- R10: Synchronous active-high reset sets phase 0, `ale_o` high, `mcyc_idx_o` 0, `last_cyc_o` 0, all ticks 0, the legacy-rate count to its start and every timer to the 12-clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_count_i | input | 3 | Machine cycles of the next instruction (1..5 valid) |
| tmr_fast_i | input | 3 | Per-timer rate select: 1 = every machine cycle, 0 = every 12 clocks |
| phase_o | output | 4 | One-hot phase of the current machine cycle |
| ale_o | output | 1 | Address-latch-enable, high in phases 0 and 1 |
| last_cyc_o | output | 1 | High in the final clock of an instruction |
| mcyc_idx_o | output | 3 | Index of the running machine cycle within the instruction |
| tmr_tick_o | output | 3 | Per-timer increment-enable pulse |

## Verification
The assertions rely on only two things about the inputs. Reset is held at the first clock edge, and `cyc_count_i` is a 3-bit value, so every code from 0 to 7 is legal input and is either used or clamped. The stimulus draws `cyc_count_i` uniformly over all eight codes, so the clamped codes appear often. It flips the timer select bits at random negative edges, which places select changes at every phase of a machine cycle. Directed runs measure the spacing between final-cycle flags and between tick pulses for fixed settings.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int unsigned CNT_W         = 3;
  localparam int unsigned MAX_INSTR_CYC = 5;

  // Clamp a decoder cycle count to the legal range; out-of-range means one cycle.
  function automatic logic [CNT_W-1:0] clamp_len(input logic [CNT_W-1:0] raw,
                                                 input int unsigned       max_cyc);
    logic [CNT_W-1:0] res;
    if (raw == '0 || int'(raw) > int'(max_cyc))
      res = CNT_W'(1);
    else
      res = raw;
    return res;
  endfunction

endpackage

// File: rtl/mcyc_phase_ring.sv
module mcyc_phase_ring #(
  parameter int unsigned NUM_PHASES = 4,
  parameter int unsigned ALE_PHASES = NUM_PHASES / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [NUM_PHASES-1:0] phase_q,
  output logic                  ale_q,
  output logic                  mc_end,
  output logic                  pre_end
);

  logic [NUM_PHASES-1:0] phase_d;

  assign phase_d = {phase_q[NUM_PHASES-2:0], phase_q[NUM_PHASES-1]};
  assign mc_end  = phase_q[NUM_PHASES-1];
  assign pre_end = phase_q[NUM_PHASES-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= NUM_PHASES'(1);
      ale_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      ale_q   <= |phase_d[ALE_PHASES-1:0];
    end
  end

endmodule

// File: rtl/mcyc_instr_seq.sv
module mcyc_instr_seq
  import mcyc_pkg::*;
#(
  parameter int unsigned MAX_CYC = MAX_INSTR_CYC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mc_end,
  input  logic             pre_end,
  input  logic [CNT_W-1:0] cyc_count_i,
  output logic [CNT_W-1:0] idx_q,
  output logic             last_q
);

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_clamped;
  logic             at_final;

  assign len_clamped = clamp_len(cyc_count_i, MAX_CYC);
  assign at_final    = (idx_q == len_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      len_q  <= len_clamped;
      last_q <= 1'b0;
    end else begin
      if (mc_end) begin
        if (at_final) begin
          idx_q <= '0;
          len_q <= len_clamped;
        end else begin
          idx_q <= idx_q + CNT_W'(1);
        end
      end
      last_q <= pre_end && at_final;
    end
  end

endmodule

// File: rtl/mcyc_tick_gen.sv
module mcyc_tick_gen #(
  parameter int unsigned N_TIMERS    = 3,
  parameter int unsigned SLOW_DIV_MC = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mc_end,
  input  logic                pre_end,
  input  logic [N_TIMERS-1:0] tmr_fast_i,
  output logic [N_TIMERS-1:0] tick_q
);

  localparam int unsigned DIV_W = (SLOW_DIV_MC > 1) ? $clog2(SLOW_DIV_MC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV_MC - 1);

  logic [DIV_W-1:0]    div_q;
  logic [N_TIMERS-1:0] sel_q;
  logic [N_TIMERS-1:0] tick_d;
  logic                slow_hit;

  assign slow_hit = (div_q == DIV_LAST);

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    assign tick_d[g] = pre_end && (sel_q[g] || slow_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sel_q  <= '0;
      tick_q <= '0;
    end else begin
      if (mc_end) begin
        div_q <= slow_hit ? '0 : div_q + DIV_W'(1);
        sel_q <= tmr_fast_i;
      end
      tick_q <= tick_d;
    end
  end

endmodule

// File: rtl/mcyc_timing_gen.sv
module mcyc_timing_gen
  import mcyc_pkg::*;
#(
  parameter int unsigned NUM_PHASES  = 4,
  parameter int unsigned N_TIMERS    = 3,
  parameter int unsigned SLOW_DIV_MC = 3,
  parameter int unsigned MAX_CYC     = MAX_INSTR_CYC
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CNT_W-1:0]      cyc_count_i,
  input  logic [N_TIMERS-1:0]   tmr_fast_i,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  ale_o,
  output logic                  last_cyc_o,
  output logic [CNT_W-1:0]      mcyc_idx_o,
  output logic [N_TIMERS-1:0]   tmr_tick_o
);

  logic mc_end;
  logic pre_end;

  mcyc_phase_ring #(
    .NUM_PHASES (NUM_PHASES)
  ) u_ring (
    .clk     (clk),
    .rst     (rst),
    .phase_q (phase_o),
    .ale_q   (ale_o),
    .mc_end  (mc_end),
    .pre_end (pre_end)
  );

  mcyc_instr_seq #(
    .MAX_CYC (MAX_CYC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .mc_end      (mc_end),
    .pre_end     (pre_end),
    .cyc_count_i (cyc_count_i),
    .idx_q       (mcyc_idx_o),
    .last_q      (last_cyc_o)
  );

  mcyc_tick_gen #(
    .N_TIMERS    (N_TIMERS),
    .SLOW_DIV_MC (SLOW_DIV_MC)
  ) u_tick (
    .clk        (clk),
    .rst        (rst),
    .mc_end     (mc_end),
    .pre_end    (pre_end),
    .tmr_fast_i (tmr_fast_i),
    .tick_q     (tmr_tick_o)
  );

endmodule

// File: rtl/mcyc_timing_gen_chk.sv
module mcyc_timing_gen_chk
  import mcyc_pkg::*;
#(
  parameter int unsigned NUM_PHASES = 4,
  parameter int unsigned N_TIMERS   = 3,
  parameter int unsigned MAX_CYC    = MAX_INSTR_CYC
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_PHASES-1:0] phase_o,
  input logic                  ale_o,
  input logic                  last_cyc_o,
  input logic [CNT_W-1:0]      mcyc_idx_o,
  input logic [N_TIMERS-1:0]   tmr_tick_o
);

  localparam int unsigned ALE_PHASES = NUM_PHASES / 2;

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_o) == 1); // R1

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    phase_o[NUM_PHASES-1] |=> phase_o[0]); // R1

  AST_ALE_HALF: assert property (@(posedge clk) disable iff (rst)
    ale_o == (|phase_o[ALE_PHASES-1:0])); // R2

  AST_LAST_IN_FINAL_PHASE: assert property (@(posedge clk) disable iff (rst)
    last_cyc_o |-> phase_o[NUM_PHASES-1]); // R3

  AST_IDX_STEADY: assert property (@(posedge clk) disable iff (rst)
    !phase_o[NUM_PHASES-1] |=> $stable(mcyc_idx_o)); // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase_o[NUM_PHASES-1] && !last_cyc_o) |=> mcyc_idx_o == $past(mcyc_idx_o) + CNT_W'(1)); // R3

  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (rst)
    last_cyc_o |=> mcyc_idx_o == '0); // R4

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(mcyc_idx_o) < int'(MAX_CYC)); // R6

  AST_TICK_IN_FINAL_PHASE: assert property (@(posedge clk) disable iff (rst)
    (|tmr_tick_o) |-> phase_o[NUM_PHASES-1]); // R7

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (phase_o == NUM_PHASES'(1)) && ale_o && !last_cyc_o && (tmr_tick_o == '0)); // R10

endmodule

bind mcyc_timing_gen mcyc_timing_gen_chk #(
  .NUM_PHASES (NUM_PHASES),
  .N_TIMERS   (N_TIMERS),
  .MAX_CYC    (MAX_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase_o    (phase_o),
  .ale_o      (ale_o),
  .last_cyc_o (last_cyc_o),
  .mcyc_idx_o (mcyc_idx_o),
  .tmr_tick_o (tmr_tick_o)
);

// File: tb/mcyc_timing_gen_tb.sv
module mcyc_timing_gen_tb;

  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cc  = 3'd3;
  logic [NT-1:0] fast = '0;
  logic [3:0]    phase_o;
  logic          ale_o;
  logic          last_cyc_o;
  logic [2:0]    mcyc_idx_o;
  logic [NT-1:0] tmr_tick_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit mon_en = 1'b0;

  // independent reference state
  int            m_t   = 0;
  int            m_len = 1;
  int            m_idx = 0;
  logic [NT-1:0] m_sel = '0;

  always #4 clk = ~clk;

  mcyc_timing_gen u_dut (
    .clk         (clk),
    .rst         (rst),
    .cyc_count_i (cc),
    .tmr_fast_i  (fast),
    .phase_o     (phase_o),
    .ale_o       (ale_o),
    .last_cyc_o  (last_cyc_o),
    .mcyc_idx_o  (mcyc_idx_o),
    .tmr_tick_o  (tmr_tick_o)
  );

  function automatic int legal_len(input logic [2:0] v);
    return (v == 3'd0 || v > 3'd5) ? 1 : int'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_t   = 0;
      m_len = legal_len(cc);
      m_idx = 0;
      m_sel = '0;
    end else begin
      m_t++;
      if (m_t % 4 == 0) begin
        if (m_idx == m_len - 1) begin
          m_idx = 0;
          m_len = legal_len(cc);
        end else begin
          m_idx++;
        end
        m_sel = fast;
      end
    end
  end

  // cycle-by-cycle comparison against the reference state
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      int ph;
      logic [3:0] e_ph;
      ph   = m_t % 4;
      e_ph = 4'b0001 << ph;
      chk(phase_o == e_ph, "R1", "phase", int'(phase_o), int'(e_ph));
      chk(ale_o == (ph < 2), "R2", "ale", int'(ale_o), int'(ph < 2));
      chk(last_cyc_o == (ph == 3 && m_idx == m_len - 1), "R3", "last",
          int'(last_cyc_o), int'(ph == 3 && m_idx == m_len - 1));
      chk(int'(mcyc_idx_o) == m_idx, "R4", "idx", int'(mcyc_idx_o), m_idx);
      for (int i = 0; i < NT; i++) begin
        bit e_tk;
        e_tk = (ph == 3) && (m_sel[i] || ((m_t / 4) % 3 == 2));
        if (m_sel[i])
          chk(tmr_tick_o[i] == e_tk, "R8/R9", "fast tick", int'(tmr_tick_o[i]), int'(e_tk));
        else
          chk(tmr_tick_o[i] == e_tk, "R7/R9", "slow tick", int'(tmr_tick_o[i]), int'(e_tk));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      report();
      $finish;
    end
  end

  task automatic measure_len(input logic [2:0] v, input int exp, input string req);
    int n;
    cc = v;
    @(negedge clk);
    while (!last_cyc_o) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!last_cyc_o);
    chk(n == exp, req, "instruction clocks", n, exp);
  endtask

  task automatic measure_tick(input int t, input int exp, input string req);
    int n;
    @(negedge clk);
    while (!tmr_tick_o[t]) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tmr_tick_o[t]);
    chk(n == exp, req, "tick spacing", n, exp);
  endtask

  initial begin
    int first;
    void'($urandom(32'd20240611));
    rst  = 1'b1;
    cc   = 3'd3;
    fast = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(phase_o == 4'b0001, "R10", "reset phase", int'(phase_o), 1);
    chk(ale_o == 1'b1, "R10", "reset ale", int'(ale_o), 1);
    chk(last_cyc_o == 1'b0, "R10", "reset last", int'(last_cyc_o), 0);
    chk(mcyc_idx_o == 3'd0, "R10", "reset idx", int'(mcyc_idx_o), 0);
    chk(tmr_tick_o == '0, "R10", "reset ticks", int'(tmr_tick_o), 0);
    rst    = 1'b0;
    mon_en = 1'b1;

    // R4: count held during reset sets the first instruction (3 cycles -> last at clock 11)
    // R7: first legacy tick on clock 11
    first = 0;
    while (!last_cyc_o) begin
      @(negedge clk);
      first++;
    end
    chk(first == 11, "R4", "first last clock", first, 11);
    chk(tmr_tick_o[0] == 1'b1, "R7", "first slow tick", int'(tmr_tick_o[0]), 1);

    measure_tick(0, 12, "R7");
    fast = 3'b010;
    measure_tick(1, 4, "R8");
    measure_tick(0, 12, "R7");
    fast = 3'b000;

    measure_len(3'd2, 8,  "R5");
    measure_len(3'd3, 12, "R5");
    measure_len(3'd5, 20, "R3");
    measure_len(3'd1, 4,  "R3");
    measure_len(3'd0, 4,  "R6");
    measure_len(3'd6, 4,  "R6");
    measure_len(3'd7, 4,  "R6");

    // constrained random: any count code, select bits flipping at any phase
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      cc = 3'($urandom_range(7));
      if ($urandom_range(4) == 0) fast = NT'($urandom);
    end

    @(negedge clk);
    mon_en = 1'b0;
    report();
    $finish;
  end

endmodule